// File: doc/BRIEF.md
# Variable Block-Size SAD Adder Tree

This block scores one candidate position for motion estimation. It takes a 16x16 current macroblock and a 16x16 candidate patch from the reference frame. It forms the 256 absolute pixel differences in parallel and reduces them through an adder tree within one cycle. The tree first produces the sixteen 4x4 sub-block SADs. Every larger partition is then built only by adding those sub-block sums, so one pass gives the SADs of all seven partition shapes: 41 results in total.

The block keeps no partial sums from one cycle to the next. An upstream scanner can present a new candidate on every clock. A downstream selector then receives a complete set of registered partition scores one cycle later, together with a valid flag. Supporting several partition shapes adds adders to the tree but no storage.

Top module: `vbs_sad_tree`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high. It is low after an edge at which `in_valid` was low.
- R2: The pixel at row r, column c (0..15) of each macroblock occupies bits [8*(16r+c)+7 : 8*(16r+c)]. `sad_4x4` slot k (12 bits, bits [12k+11:12k]) holds the sum of |cur-cand| over the 4x4 region at block row k/4 and block column k%4. The sixteen sub-blocks are numbered in raster order.
- R3: `sad_8x4` holds 8 slots of 13 bits, one per 8-wide by 4-tall region. Each slot is the sum of a horizontal pair of sub-blocks. Slot k covers region row k/2, region column k%2.
- R4: `sad_4x8` holds 8 slots of 13 bits, one per 4-wide by 8-tall region. Each slot is the sum of a vertical pair of sub-blocks. Slot k covers region row k/4, region column k%4.
- R5: `sad_8x8` holds 4 slots of 14 bits for the 8x8 quadrants in raster order (slot 0 top-left, slot 3 bottom-right). Each slot equals the sum of its four sub-block SADs.
- R6: `sad_16x8` holds 2 slots of 15 bits: slot 0 is the top half and slot 1 the bottom half. `sad_8x16` holds 2 slots of 15 bits: slot 0 is the left half and slot 1 the right half.
- R7: `sad_16x16` (16 bits) is the SAD of the whole macroblock. It is exact up to the largest possible value, 65280, with no overflow. It equals the sum of both `sad_16x8` halves and also the sum of both `sad_8x16` halves.
- R8: While `in_valid` is low, every SAD output keeps its previous value, whatever the pixel inputs do.
- R9: While `rst_n` is low, `out_valid` and all SAD outputs are zero.
- R10: Each result depends only on the pixels presented with it. Candidates sent on consecutive cycles give independent, correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel inputs hold a candidate to score |
| cur_pix | input | 2048 | Current macroblock, 256 pixels of 8 bits |
| cand_pix | input | 2048 | Candidate reference patch, 256 pixels of 8 bits |
| out_valid | output | 1 | SAD outputs hold a fresh result |
| sad_4x4 | output | 192 | Sixteen 4x4 SADs, 12 bits each |
| sad_8x4 | output | 104 | Eight 8-wide x 4-tall SADs, 13 bits each |
| sad_4x8 | output | 104 | Eight 4-wide x 8-tall SADs, 13 bits each |
| sad_8x8 | output | 56 | Four 8x8 SADs, 14 bits each |
| sad_16x8 | output | 30 | Two 16-wide x 8-tall SADs, 15 bits each |
| sad_8x16 | output | 30 | Two 8-wide x 16-tall SADs, 15 bits each |
| sad_16x16 | output | 16 | Whole-macroblock SAD |

## Verification
The corner that is hardest to reach from the ports is an error in how the merge stage wires sub-blocks into a partition. Random pixels spread error over every sub-block, so a wrong pairing such as vertical in place of horizontal can still give plausible totals. To expose it, the stimulus sends sixteen candidates in a row, each with one non-zero difference placed at the far corner of a different sub-block, with a magnitude unique to that sub-block. Each partition result must then come out either zero or that exact value. Full-scale all-255 differences push every width to its ceiling, and cycles with valid low and changing pixels probe the hold behaviour.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;
  // Sub-block grid edge: the macroblock is GRID x GRID sub-blocks.
  localparam int GRID = 4;
  localparam int NBLK = GRID * GRID;

  // Bits needed to hold a sum of npix differences of pix_w bits each.
  function automatic int sum_width(input int pix_w, input int npix);
    return pix_w + $clog2(npix);
  endfunction
endpackage

// File: rtl/vbs_sad_blk.sv
// Absolute differences and local sum for one sub-block.
module vbs_sad_blk #(
  parameter int PIX_W = 8,
  parameter int SB    = 4,
  parameter int SW    = 12
) (
  input  logic [SB*SB*PIX_W-1:0] cur_blk,
  input  logic [SB*SB*PIX_W-1:0] cand_blk,
  output logic [SW-1:0]          blk_sad
);
  localparam int NPIX = SB * SB;

  logic [PIX_W-1:0] diff [NPIX];

  for (genvar p = 0; p < NPIX; p++) begin : g_pe
    logic [PIX_W-1:0] a, b;
    assign a = cur_blk[p*PIX_W +: PIX_W];
    assign b = cand_blk[p*PIX_W +: PIX_W];
    assign diff[p] = (a > b) ? (a - b) : (b - a);
  end

  always_comb begin
    blk_sad = '0;
    for (int p = 0; p < NPIX; p++) begin
      blk_sad = blk_sad + SW'(diff[p]);
    end
  end
endmodule

// File: rtl/vbs_sad_merge.sv
// Builds every larger partition from the sixteen sub-block sums.
module vbs_sad_merge
  import vbs_sad_pkg::*;
#(
  parameter int W4 = 12
) (
  input  logic [W4-1:0]   s4   [NBLK],
  output logic [W4:0]     s_h  [NBLK/2],
  output logic [W4:0]     s_v  [NBLK/2],
  output logic [W4+1:0]   s_q  [4],
  output logic [W4+2:0]   s_tb [2],
  output logic [W4+2:0]   s_lr [2],
  output logic [W4+3:0]   s_all
);
  localparam int WH = W4 + 1;
  localparam int WQ = W4 + 2;
  localparam int WT = W4 + 3;
  localparam int WA = W4 + 4;
  localparam int HC = GRID / 2;

  always_comb begin
    // horizontal pairs: region rows = GRID, region cols = GRID/2
    for (int r = 0; r < GRID; r++) begin
      for (int h = 0; h < HC; h++) begin
        s_h[r*HC+h] = WH'(s4[r*GRID+2*h]) + WH'(s4[r*GRID+2*h+1]);
      end
    end
    // vertical pairs: region rows = GRID/2, region cols = GRID
    for (int vr = 0; vr < HC; vr++) begin
      for (int c = 0; c < GRID; c++) begin
        s_v[vr*GRID+c] = WH'(s4[(2*vr)*GRID+c]) + WH'(s4[(2*vr+1)*GRID+c]);
      end
    end
    // quadrants from stacked horizontal pairs
    for (int qr = 0; qr < 2; qr++) begin
      for (int qc = 0; qc < 2; qc++) begin
        s_q[qr*2+qc] = WQ'(s_h[(2*qr)*HC+qc]) + WQ'(s_h[(2*qr+1)*HC+qc]);
      end
    end
    for (int t = 0; t < 2; t++) begin
      s_tb[t] = WT'(s_q[2*t]) + WT'(s_q[2*t+1]);
      s_lr[t] = WT'(s_q[t])   + WT'(s_q[2+t]);
    end
    s_all = WA'(s_tb[0]) + WA'(s_tb[1]);
  end
endmodule

// File: rtl/vbs_sad_tree.sv
module vbs_sad_tree
  import vbs_sad_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SB    = 4,
  localparam int MB   = SB * GRID,
  localparam int NPX  = MB * MB,
  localparam int W4   = sum_width(PIX_W, SB*SB),
  localparam int WH   = W4 + 1,
  localparam int WQ   = W4 + 2,
  localparam int WT   = W4 + 3,
  localparam int WA   = W4 + 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NPX*PIX_W-1:0]   cur_pix,
  input  logic [NPX*PIX_W-1:0]   cand_pix,
  output logic                   out_valid,
  output logic [NBLK*W4-1:0]     sad_4x4,
  output logic [NBLK/2*WH-1:0]   sad_8x4,
  output logic [NBLK/2*WH-1:0]   sad_4x8,
  output logic [4*WQ-1:0]        sad_8x8,
  output logic [2*WT-1:0]        sad_16x8,
  output logic [2*WT-1:0]        sad_8x16,
  output logic [WA-1:0]          sad_16x16
);
  localparam int BW = SB * SB * PIX_W;

  // ---- sub-block gather and difference sums ----
  logic [W4-1:0] c4 [NBLK];

  for (genvar gb = 0; gb < NBLK; gb++) begin : g_blk
    logic [BW-1:0] cb, kb;
    always_comb begin
      for (int r = 0; r < SB; r++) begin
        for (int c = 0; c < SB; c++) begin
          cb[(r*SB+c)*PIX_W +: PIX_W] =
            cur_pix[(((gb/GRID)*SB+r)*MB + (gb%GRID)*SB + c)*PIX_W +: PIX_W];
          kb[(r*SB+c)*PIX_W +: PIX_W] =
            cand_pix[(((gb/GRID)*SB+r)*MB + (gb%GRID)*SB + c)*PIX_W +: PIX_W];
        end
      end
    end
    vbs_sad_blk #(.PIX_W(PIX_W), .SB(SB), .SW(W4)) u_blk (
      .cur_blk (cb),
      .cand_blk(kb),
      .blk_sad (c4[gb])
    );
  end

  // ---- partition merge ----
  logic [WH-1:0] c_h [NBLK/2];
  logic [WH-1:0] c_v [NBLK/2];
  logic [WQ-1:0] c_q [4];
  logic [WT-1:0] c_tb [2];
  logic [WT-1:0] c_lr [2];
  logic [WA-1:0] c_all;

  vbs_sad_merge #(.W4(W4)) u_merge (
    .s4  (c4),
    .s_h (c_h),
    .s_v (c_v),
    .s_q (c_q),
    .s_tb(c_tb),
    .s_lr(c_lr),
    .s_all(c_all)
  );

  // ---- output registers: next state then flops ----
  logic [NBLK*W4-1:0]   n_4,  q_4;
  logic [NBLK/2*WH-1:0] n_h,  q_h, n_v, q_v;
  logic [4*WQ-1:0]      n_q,  q_q;
  logic [2*WT-1:0]      n_tb, q_tb, n_lr, q_lr;
  logic [WA-1:0]        n_all, q_all;
  logic                 q_vld;

  always_comb begin
    n_4 = q_4; n_h = q_h; n_v = q_v; n_q = q_q;
    n_tb = q_tb; n_lr = q_lr; n_all = q_all;
    if (in_valid) begin
      for (int i = 0; i < NBLK; i++)   n_4[i*W4 +: W4] = c4[i];
      for (int i = 0; i < NBLK/2; i++) begin
        n_h[i*WH +: WH] = c_h[i];
        n_v[i*WH +: WH] = c_v[i];
      end
      for (int i = 0; i < 4; i++)      n_q[i*WQ +: WQ] = c_q[i];
      for (int i = 0; i < 2; i++) begin
        n_tb[i*WT +: WT] = c_tb[i];
        n_lr[i*WT +: WT] = c_lr[i];
      end
      n_all = c_all;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_4 <= '0; q_h <= '0; q_v <= '0; q_q <= '0;
      q_tb <= '0; q_lr <= '0; q_all <= '0;
    end else begin
      q_vld <= in_valid;
      q_4 <= n_4; q_h <= n_h; q_v <= n_v; q_q <= n_q;
      q_tb <= n_tb; q_lr <= n_lr; q_all <= n_all;
    end
  end

  assign out_valid = q_vld;
  assign sad_4x4   = q_4;
  assign sad_8x4   = q_h;
  assign sad_4x8   = q_v;
  assign sad_8x8   = q_q;
  assign sad_16x8  = q_tb;
  assign sad_8x16  = q_lr;
  assign sad_16x16 = q_all;

  // ---- assertions ----
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sad_4x4) && $stable(sad_8x8) && $stable(sad_16x16)
                   && $stable(sad_8x4) && $stable(sad_4x8)));

  a_r7_total_rows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sad_16x16 == WA'(sad_16x8[0 +: WT]) + WA'(sad_16x8[WT +: WT])));
  a_r7_total_cols: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sad_16x16 == WA'(sad_8x16[0 +: WT]) + WA'(sad_8x16[WT +: WT])));

  for (genvar gq = 0; gq < 4; gq++) begin : g_chk_q
    localparam int B0 = (gq/2)*2*GRID + (gq%2)*2;
    a_r5_quad_from_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sad_8x8[gq*WQ +: WQ] ==
                     WQ'(sad_4x4[B0*W4 +: W4]) + WQ'(sad_4x4[(B0+1)*W4 +: W4]) +
                     WQ'(sad_4x4[(B0+GRID)*W4 +: W4]) +
                     WQ'(sad_4x4[(B0+GRID+1)*W4 +: W4])));
  end

  for (genvar gk = 0; gk < NBLK; gk++) begin : g_chk_b
    a_r2_block_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(sad_4x4[gk*W4 +: W4]) <= SB*SB*((1 << PIX_W) - 1)));
  end
endmodule

// File: tb/vbs_sad_tree_tb.sv
module vbs_sad_tree_tb;
  localparam int PW = 8;
  localparam int W4 = 12, WH = 13, WQ = 14, WT = 15, WA = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [2047:0] cur_pix, cand_pix;
  logic out_valid;
  logic [16*W4-1:0] sad_4x4;
  logic [8*WH-1:0]  sad_8x4, sad_4x8;
  logic [4*WQ-1:0]  sad_8x8;
  logic [2*WT-1:0]  sad_16x8, sad_8x16;
  logic [WA-1:0]    sad_16x16;

  always #10 clk = ~clk;

  vbs_sad_tree u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cur_pix(cur_pix), .cand_pix(cand_pix),
    .out_valid(out_valid), .sad_4x4(sad_4x4), .sad_8x4(sad_8x4),
    .sad_4x8(sad_4x8), .sad_8x8(sad_8x8), .sad_16x8(sad_16x8),
    .sad_8x16(sad_8x16), .sad_16x16(sad_16x16)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // ---- behavioural model: region sums straight from pixels ----
  int e44[16], e84[8], e48[8], e88[4], e168[2], e816[2], e1616;
  bit ev;

  function automatic int pix(input logic [2047:0] v, input int r, input int c);
    return int'(v[8*(16*r+c) +: 8]);
  endfunction

  function automatic int region(input int x0, input int y0, input int w, input int h);
    int s = 0;
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) begin
        int d = pix(cur_pix, y, x) - pix(cand_pix, y, x);
        s += (d < 0) ? -d : d;
      end
    return s;
  endfunction

  // slot k of a w x h grid, raster order, cols = 16/w
  function automatic int shape(input int w, input int h, input int k);
    return region((k % (16/w)) * w, (k / (16/w)) * h, w, h);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev = 0;
      foreach (e44[i]) e44[i] = 0;
      foreach (e84[i]) begin e84[i] = 0; e48[i] = 0; end
      foreach (e88[i]) e88[i] = 0;
      foreach (e168[i]) begin e168[i] = 0; e816[i] = 0; end
      e1616 = 0;
    end else begin
      ev = in_valid;
      if (in_valid) begin
        foreach (e44[i])  e44[i]  = shape(4, 4, i);
        foreach (e84[i])  e84[i]  = shape(8, 4, i);
        foreach (e48[i])  e48[i]  = shape(4, 8, i);
        foreach (e88[i])  e88[i]  = shape(8, 8, i);
        foreach (e168[i]) e168[i] = shape(16, 8, i);
        foreach (e816[i]) e816[i] = shape(8, 16, i);
        e1616 = shape(16, 16, 0);
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    check("R1", "out_valid", int'(out_valid), int'(ev));
    for (int i = 0; i < 16; i++) check("R2", $sformatf("4x4[%0d]", i), int'(sad_4x4[i*W4 +: W4]), e44[i]);
    for (int i = 0; i < 8; i++)  check("R3", $sformatf("8x4[%0d]", i), int'(sad_8x4[i*WH +: WH]), e84[i]);
    for (int i = 0; i < 8; i++)  check("R4", $sformatf("4x8[%0d]", i), int'(sad_4x8[i*WH +: WH]), e48[i]);
    for (int i = 0; i < 4; i++)  check("R5", $sformatf("8x8[%0d]", i), int'(sad_8x8[i*WQ +: WQ]), e88[i]);
    for (int i = 0; i < 2; i++) begin
      check("R6", $sformatf("16x8[%0d]", i), int'(sad_16x8[i*WT +: WT]), e168[i]);
      check("R6", $sformatf("8x16[%0d]", i), int'(sad_8x16[i*WT +: WT]), e816[i]);
    end
    check("R7", "16x16", int'(sad_16x16), e1616);
  end

  task automatic fill(input int mode);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        case (mode)
          0: begin cur_pix[8*(16*r+c) +: 8] = 8'd0;   cand_pix[8*(16*r+c) +: 8] = 8'd0;   end
          1: begin cur_pix[8*(16*r+c) +: 8] = 8'd255; cand_pix[8*(16*r+c) +: 8] = 8'd0;   end
          2: begin cur_pix[8*(16*r+c) +: 8] = 8'd0;   cand_pix[8*(16*r+c) +: 8] = 8'd255; end
          3: begin cur_pix[8*(16*r+c) +: 8] = 8'($urandom); cand_pix[8*(16*r+c) +: 8] = 8'($urandom); end
          default: begin
            cur_pix[8*(16*r+c) +: 8]  = 8'(r*16 + c);
            cand_pix[8*(16*r+c) +: 8] = 8'(c*16 + r);
          end
        endcase
      end
  endtask

  initial begin
    rst_n = 0; in_valid = 0;
    fill(3);
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    check("R9", "out_valid in reset", int'(out_valid), 0);
    check("R9", "16x16 in reset", int'(sad_16x16), 0);
    check("R9", "4x4 in reset", int'(sad_4x4 != '0), 0);
    rst_n = 1;
    @(negedge clk);

    // R10: back-to-back distinct candidates
    in_valid = 1; fill(0); @(negedge clk);
    fill(1); @(negedge clk);          // R7: full scale 65280
    fill(2); @(negedge clk);
    for (int n = 0; n < 5; n++) begin fill(3); @(negedge clk); end
    fill(4); @(negedge clk);

    // R3/R4/R5: one marked difference per sub-block, at its far corner
    for (int b = 0; b < 16; b++) begin
      fill(0);
      cand_pix[8*(16*((b/4)*4+3) + (b%4)*4+3) +: 8] = 8'(b*13 + 7);
      @(negedge clk);
    end

    // R8: valid low, pixels changing
    in_valid = 0;
    for (int n = 0; n < 4; n++) begin fill(3); @(negedge clk); end
    in_valid = 1; fill(3); @(negedge clk);
    in_valid = 0; fill(1); @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule